// File: doc/BRIEF.md
# DDR SDRAM Command Bus Monitor

This block watches the command pins of a DDR SDRAM bus and samples them on every rising clock edge. It turns the chip-select, row-strobe, column-strobe and write-enable levels into a command. The clock-enable history tells auto refresh apart from self-refresh entry, and the A10 pin tells single-bank from all-bank precharge and plain from auto-precharging reads and writes. The monitor keeps an open or closed flag and a set of age counters for each of the four banks. For each sampled command it reports the decoded command, the bank it targets and one error code for the most important rule the command breaks.

The block is passive. It drives nothing onto the memory bus. A controller under test or a system-level checker places it on the command bus and reads its outputs one cycle later. All spacing limits are parameters counted in clock cycles. When a command breaks a rule, the bank state is still updated as if the command had been accepted, so later checks follow what the memory device would have done.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Outputs are registered: a command sampled at edge k appears on `cmd_o` after edge k. When `cs_n` is high the command is masked, so `cmd_o` is NOP (0) and `err_o` is 0. When `cs_n` is low, {ras_n,cas_n,we_n} decodes as follows: 000 MRS (1), 001 refresh, 011 ACT (4), 010 precharge, 101 read, 100 write, 110 BST (11), 111 NOP (0).
- R2: The target bank index is {ba[1],ba[0]} and appears on `bank_o`. A precharge with A10 high reports PREA (6), raises `all_banks_o` and closes every bank whatever the bank address. With A10 low it reports PRE (5). Reads and writes report RD (7) / WR (9), or RDA (8) / WRA (10) when A10 is high.
- R3: A refresh code sampled with cke high on both the previous and the current edge reports REF (2). With cke high on the previous edge and low on the current one it reports SREF (3).
- R4: An ACT to an open bank raises code 2. A read or write to a closed bank raises code 3. The error lasts one cycle and the state updates as if the command were accepted.
- R5: MRS, REF or SREF issued while any bank is open raises code 5.
- R6: Any command other than NOP within T_MRD cycles after an MRS raises code 1.
- R7: A read or write fewer than T_RCD cycles after the ACT of its bank raises code 9.
- R8: A precharge of an open bank fewer than T_RAS cycles after its ACT raises code 10. A precharge fewer than BURST_CYC+T_WR cycles after a write to that bank raises code 11.
- R9: An ACT to a closed bank fewer than T_RP cycles after the bank closed raises code 6. An ACT fewer than T_RC cycles after the previous ACT of the same bank raises code 7.
- R10: An ACT fewer than T_RRD cycles after an ACT to a different bank raises code 8.
- R11: An auto-precharging read or write closes its bank BURST_CYC cycles later for a read and BURST_CYC+T_WR cycles later for a write, and tRP counts from that point. A read or write to that bank while the close is still pending raises code 4.
- R12: Reset closes all banks and sets every age to its limit. Outputs read NOP with code 0, and a command issued right after reset is legal.
- R13: When several rules are broken at once, the lowest nonzero error code is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples the command |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable as seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Address bit 10 (all-bank / auto-precharge qualifier) |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | BA_W | Bank address of the sampled command |
| all_banks_o | output | 1 | Sampled command was an all-bank precharge |
| err_o | output | 4 | Error code, 0 when legal |

## Verification
One command stream walks the banks through activate, access, precharge and refresh. It places each command exactly at or one cycle inside a spacing limit, which separates an off-by-one in every age counter from a correct boundary. A deselected cycle that carries an MRS code, and a refresh with cke falling, show masking and refresh-mode decoding apart from the plain command map. The auto-precharged write is probed by an access while the close is pending, by a read after the bank closes and by an activate exactly tRP later. This shows whether the close point is counted from the end of the burst. Commands that break two rules at once, and erroneous commands followed by dependent ones, show the priority order and that state is updated even when a command is flagged.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_MRS  = 4'd1,
    CMD_REF  = 4'd2,
    CMD_SREF = 4'd3,
    CMD_ACT  = 4'd4,
    CMD_PRE  = 4'd5,
    CMD_PREA = 4'd6,
    CMD_RD   = 4'd7,
    CMD_RDA  = 4'd8,
    CMD_WR   = 4'd9,
    CMD_WRA  = 4'd10,
    CMD_BST  = 4'd11
  } cmd_t;

  // Lower value wins when several rules are broken in one cycle.
  typedef enum logic [3:0] {
    ERR_NONE     = 4'd0,
    ERR_MRS_GAP  = 4'd1,
    ERR_ACT_OPEN = 4'd2,
    ERR_CLOSED   = 4'd3,
    ERR_AP_BUSY  = 4'd4,
    ERR_NOT_IDLE = 4'd5,
    ERR_TRP      = 4'd6,
    ERR_TRC      = 4'd7,
    ERR_TRRD     = 4'd8,
    ERR_TRCD     = 4'd9,
    ERR_TRAS     = 4'd10,
    ERR_TWR      = 4'd11
  } err_t;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic a10,
  output cmd_t cmd
);

  logic cke_prev;

  always_ff @(posedge clk) begin
    if (rst) cke_prev <= 1'b1;
    else     cke_prev <= cke;
  end

  always_comb begin
    cmd = CMD_NOP;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b000: cmd = CMD_MRS;
        3'b001: if (cke_prev) cmd = cke ? CMD_REF : CMD_SREF;
        3'b011: cmd = CMD_ACT;
        3'b010: cmd = a10 ? CMD_PREA : CMD_PRE;
        3'b101: cmd = a10 ? CMD_RDA : CMD_RD;
        3'b100: cmd = a10 ? CMD_WRA : CMD_WR;
        3'b110: cmd = CMD_BST;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          act_hit,
  input  logic          pre_hit,
  input  logic          wr_hit,
  input  logic          ap_req,
  input  logic [CW-1:0] ap_delay,
  output logic          is_open,
  output logic          ap_busy,
  output logic [CW-1:0] act_age,
  output logic [CW-1:0] pre_age,
  output logic [CW-1:0] wr_age
);

  localparam logic [CW-1:0] SAT = '1;
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] v);
    return (v == SAT) ? SAT : v + ONE;
  endfunction

  logic          open_q;
  logic [CW-1:0] ap_q;
  logic [CW-1:0] act_q, pre_q, wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      ap_q   <= '0;
      act_q  <= SAT;
      pre_q  <= SAT;
      wr_q   <= SAT;
    end else begin
      act_q <= act_hit ? ONE : bump(act_q);
      wr_q  <= wr_hit  ? ONE : bump(wr_q);
      if (act_hit) open_q <= 1'b1;
      if (pre_hit && open_q) begin
        open_q <= 1'b0;
        ap_q   <= '0;
        pre_q  <= ONE;
      end else if (ap_q == ONE) begin
        open_q <= 1'b0;
        ap_q   <= '0;
        pre_q  <= ONE;
      end else begin
        pre_q <= bump(pre_q);
        if (ap_q != '0)           ap_q <= ap_q - ONE;
        else if (ap_req && open_q) ap_q <= ap_delay;
      end
    end
  end

  assign is_open = open_q;
  assign ap_busy = (ap_q != '0);
  assign act_age = act_q;
  assign pre_age = pre_q;
  assign wr_age  = wr_q;

endmodule

// File: rtl/sdram_rule_check.sv
module sdram_rule_check
  import sdram_mon_pkg::*;
#(
  parameter int BW        = 2,
  parameter int NB        = 4,
  parameter int CW        = 6,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 6,
  parameter int T_RRD     = 2,
  parameter int T_RC      = 9,
  parameter int T_WR      = 2,
  parameter int T_MRD     = 2,
  parameter int BURST_CYC = 2
) (
  input  cmd_t          cmd,
  input  logic [BW-1:0] bank,
  input  logic [NB-1:0] open_v,
  input  logic [NB-1:0] busy_v,
  input  logic [CW-1:0] act_age [NB],
  input  logic [CW-1:0] pre_age [NB],
  input  logic [CW-1:0] wr_age  [NB],
  input  logic [CW-1:0] last_act_age,
  input  logic [BW-1:0] last_act_bank,
  input  logic [CW-1:0] mrs_age,
  output err_t          err
);

  localparam logic [CW-1:0] L_RCD = CW'(T_RCD);
  localparam logic [CW-1:0] L_RP  = CW'(T_RP);
  localparam logic [CW-1:0] L_RAS = CW'(T_RAS);
  localparam logic [CW-1:0] L_RRD = CW'(T_RRD);
  localparam logic [CW-1:0] L_RC  = CW'(T_RC);
  localparam logic [CW-1:0] L_WRG = CW'(BURST_CYC + T_WR);
  localparam logic [CW-1:0] L_MRD = CW'(T_MRD);

  logic is_act, is_rw, is_pre, is_prea, is_idle_cmd, tgt_open;
  logic f_gap, f_act_open, f_closed, f_busy, f_idle;
  logic f_trp, f_trc, f_trrd, f_trcd, f_tras, f_twr;

  always_comb begin
    is_act      = (cmd == CMD_ACT);
    is_rw       = (cmd == CMD_RD) || (cmd == CMD_RDA) || (cmd == CMD_WR) || (cmd == CMD_WRA);
    is_pre      = (cmd == CMD_PRE);
    is_prea     = (cmd == CMD_PREA);
    is_idle_cmd = (cmd == CMD_MRS) || (cmd == CMD_REF) || (cmd == CMD_SREF);
    tgt_open    = open_v[bank];

    f_gap      = (cmd != CMD_NOP) && (mrs_age < L_MRD);
    f_act_open = is_act && tgt_open;
    f_closed   = is_rw && !tgt_open;
    f_busy     = is_rw && tgt_open && busy_v[bank];
    f_idle     = is_idle_cmd && (|open_v);
    f_trp      = is_act && !tgt_open && (pre_age[bank] < L_RP);
    f_trc      = is_act && !tgt_open && (act_age[bank] < L_RC);
    f_trrd     = is_act && (last_act_bank != bank) && (last_act_age < L_RRD);
    f_trcd     = is_rw && tgt_open && (act_age[bank] < L_RCD);
    f_tras     = 1'b0;
    f_twr      = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (((is_pre && (bank == BW'(b))) || is_prea) && open_v[b]) begin
        if (act_age[b] < L_RAS) f_tras = 1'b1;
        if (wr_age[b]  < L_WRG) f_twr  = 1'b1;
      end
    end

    if      (f_gap)      err = ERR_MRS_GAP;
    else if (f_act_open) err = ERR_ACT_OPEN;
    else if (f_closed)   err = ERR_CLOSED;
    else if (f_busy)     err = ERR_AP_BUSY;
    else if (f_idle)     err = ERR_NOT_IDLE;
    else if (f_trp)      err = ERR_TRP;
    else if (f_trc)      err = ERR_TRC;
    else if (f_trrd)     err = ERR_TRRD;
    else if (f_trcd)     err = ERR_TRCD;
    else if (f_tras)     err = ERR_TRAS;
    else if (f_twr)      err = ERR_TWR;
    else                 err = ERR_NONE;
  end

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int BA_W      = 2,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 6,
  parameter int T_RRD     = 2,
  parameter int T_RC      = 9,
  parameter int T_WR      = 2,
  parameter int T_MRD     = 2,
  parameter int BURST_CYC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cke,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BA_W-1:0] ba,
  input  logic            a10,
  output logic [3:0]      cmd_o,
  output logic [BA_W-1:0] bank_o,
  output logic            all_banks_o,
  output logic [3:0]      err_o
);

  localparam int NB   = 1 << BA_W;
  localparam int SPAN = T_RCD + T_RP + T_RAS + T_RRD + T_RC + T_WR + T_MRD + BURST_CYC;
  localparam int CW   = $clog2(SPAN + 1) + 1;
  localparam logic [CW-1:0] SAT   = '1;
  localparam logic [CW-1:0] ONE   = {{(CW-1){1'b0}}, 1'b1};
  localparam logic [CW-1:0] RD_AP = CW'(BURST_CYC);
  localparam logic [CW-1:0] WR_AP = CW'(BURST_CYC + T_WR);

  cmd_t cmd;
  err_t err;

  sdram_cmd_decode u_dec (
    .clk   (clk),
    .rst   (rst),
    .cke   (cke),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .a10   (a10),
    .cmd   (cmd)
  );

  logic is_act, is_wr, is_ap;
  assign is_act = (cmd == CMD_ACT);
  assign is_wr  = (cmd == CMD_WR) || (cmd == CMD_WRA);
  assign is_ap  = (cmd == CMD_RDA) || (cmd == CMD_WRA);

  logic [NB-1:0] open_v, busy_v;
  logic [CW-1:0] act_age [NB];
  logic [CW-1:0] pre_age [NB];
  logic [CW-1:0] wr_age  [NB];

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic sel;
    assign sel = (ba == BA_W'(g));
    sdram_bank_tracker #(.CW(CW)) u_trk (
      .clk      (clk),
      .rst      (rst),
      .act_hit  (is_act && sel),
      .pre_hit  (((cmd == CMD_PRE) && sel) || (cmd == CMD_PREA)),
      .wr_hit   (is_wr && sel),
      .ap_req   (is_ap && sel),
      .ap_delay ((cmd == CMD_WRA) ? WR_AP : RD_AP),
      .is_open  (open_v[g]),
      .ap_busy  (busy_v[g]),
      .act_age  (act_age[g]),
      .pre_age  (pre_age[g]),
      .wr_age   (wr_age[g])
    );
  end

  logic [CW-1:0]   last_act_age, mrs_age;
  logic [BA_W-1:0] last_act_bank;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_act_age  <= SAT;
      last_act_bank <= '0;
      mrs_age       <= SAT;
    end else begin
      last_act_age  <= is_act ? ONE : ((last_act_age == SAT) ? SAT : last_act_age + ONE);
      if (is_act) last_act_bank <= ba;
      mrs_age       <= (cmd == CMD_MRS) ? ONE : ((mrs_age == SAT) ? SAT : mrs_age + ONE);
    end
  end

  sdram_rule_check #(
    .BW(BA_W), .NB(NB), .CW(CW),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RRD(T_RRD),
    .T_RC(T_RC), .T_WR(T_WR), .T_MRD(T_MRD), .BURST_CYC(BURST_CYC)
  ) u_rules (
    .cmd           (cmd),
    .bank          (ba),
    .open_v        (open_v),
    .busy_v        (busy_v),
    .act_age       (act_age),
    .pre_age       (pre_age),
    .wr_age        (wr_age),
    .last_act_age  (last_act_age),
    .last_act_bank (last_act_bank),
    .mrs_age       (mrs_age),
    .err           (err)
  );

  cmd_t            cmd_q;
  err_t            err_q;
  logic [BA_W-1:0] bank_q;
  logic            all_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= CMD_NOP;
      err_q  <= ERR_NONE;
      bank_q <= '0;
      all_q  <= 1'b0;
    end else begin
      cmd_q  <= cmd;
      err_q  <= err;
      bank_q <= ba;
      all_q  <= (cmd == CMD_PREA);
    end
  end

  assign cmd_o       = cmd_q;
  assign err_o       = err_q;
  assign bank_o      = bank_q;
  assign all_banks_o = all_q;

endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk
  import sdram_mon_pkg::*;
#(
  parameter int T_RRD = 2,
  parameter int T_MRD = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic       a10,
  input logic [3:0] cmd_o,
  input logic [3:0] err_o,
  input logic       all_banks_o
);

  assert_masked_R1: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (cmd_o == CMD_NOP && err_o == ERR_NONE));

  assert_prea_flag_R2: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && {ras_n, cas_n, we_n} == 3'b010 && a10) |=> all_banks_o);

  assert_reset_state_R12: assert property (@(posedge clk)
    rst |=> (cmd_o == CMD_NOP && err_o == ERR_NONE && !all_banks_o));

  assert_err_known_R13: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(err_o));

  if (T_MRD >= 2) begin : g_mrd
    assert_mrs_gap_R6: assert property (@(posedge clk) disable iff (rst)
      (cmd_o == CMD_MRS) |=> (cmd_o == CMD_NOP || err_o == ERR_MRS_GAP));
  end

  if (T_RRD >= 2) begin : g_rrd
    assert_act_spacing_R10: assert property (@(posedge clk) disable iff (rst)
      (cmd_o == CMD_ACT && err_o == ERR_NONE) |=> !(cmd_o == CMD_ACT && err_o == ERR_NONE));
  end

endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(.T_RRD(T_RRD), .T_MRD(T_MRD)) u_chk (.*);

// File: tb/sdram_cmd_monitor_bench.sv
module sdram_cmd_monitor_bench;
  import sdram_mon_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cke = 1'b1;
  logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = 2'b00;
  logic       a10 = 1'b0;
  logic [3:0] cmd_o, err_o;
  logic [1:0] bank_o;
  logic       all_banks_o;

  sdram_cmd_monitor u_sdram_cmd_monitor (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .cmd_o(cmd_o), .bank_o(bank_o),
    .all_banks_o(all_banks_o), .err_o(err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [3:0] c;
    logic [1:0] b;
    logic       chk_b;
    logic       all;
    logic [3:0] e;
    string      tag;
    int         due;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare each expected item in the cycle after its command was sampled.
  always @(negedge clk) begin
    exp_t e;
    while (q.size() > 0 && q[0].due <= cyc) begin
      e = q.pop_front();
      n_chk++;
      if (cmd_o !== e.c || err_o !== e.e || all_banks_o !== e.all ||
          (e.chk_b && bank_o !== e.b)) begin
        n_fail++;
        $display("FAIL %s: cmd %0d exp %0d, err %0d exp %0d, all %0b exp %0b, bank %0d exp %0d",
                 e.tag, cmd_o, e.c, err_o, e.e, all_banks_o, e.all, bank_o, e.b);
      end
    end
  end

  task automatic issue(input logic cs, input logic [2:0] rcw, input logic [1:0] b,
                       input logic ap, input logic k, input cmd_t ec, input err_t ee,
                       input string tag);
    exp_t e;
    @(negedge clk);
    cke = k; cs_n = cs; {ras_n, cas_n, we_n} = rcw; ba = b; a10 = ap;
    e.c     = ec;
    e.b     = b;
    e.chk_b = (ec == CMD_ACT) || (ec == CMD_PRE) || (ec == CMD_RD) || (ec == CMD_RDA) ||
              (ec == CMD_WR) || (ec == CMD_WRA);
    e.all   = (ec == CMD_PREA);
    e.e     = ee;
    e.tag   = tag;
    e.due   = cyc + 1;
    q.push_back(e);
  endtask

  task automatic cmd(input logic [2:0] rcw, input logic [1:0] b, input logic ap,
                     input cmd_t ec, input err_t ee, input string tag);
    issue(1'b0, rcw, b, ap, 1'b1, ec, ee, tag);
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) cmd(3'b111, 2'b00, 1'b0, CMD_NOP, ERR_NONE, "R1 nop");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (cmd_o !== CMD_NOP || err_o !== ERR_NONE || all_banks_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R12 reset: cmd %0d err %0d all %0b exp 0 0 0", cmd_o, err_o, all_banks_o);
    end
    rst = 1'b0;

    cmd(3'b011, 2'd0, 1'b0, CMD_ACT,  ERR_NONE,     "R12 act legal after reset");      // c0
    cmd(3'b011, 2'd1, 1'b0, CMD_ACT,  ERR_TRRD,     "R10 act other bank too soon");    // c1
    cmd(3'b101, 2'd0, 1'b0, CMD_RD,   ERR_TRCD,     "R7 read one cycle early");        // c2
    cmd(3'b101, 2'd0, 1'b0, CMD_RD,   ERR_NONE,     "R7 read at tRCD");                // c3
    cmd(3'b010, 2'd0, 1'b0, CMD_PRE,  ERR_TRAS,     "R8 precharge before tRAS");       // c4
    cmd(3'b101, 2'd0, 1'b0, CMD_RD,   ERR_CLOSED,   "R4 read closed bank");            // c5
    cmd(3'b011, 2'd0, 1'b0, CMD_ACT,  ERR_TRP,      "R9 R13 tRP wins over tRC");       // c6
    cmd(3'b011, 2'd0, 1'b0, CMD_ACT,  ERR_ACT_OPEN, "R4 act open bank");               // c7
    cmd(3'b001, 2'd0, 1'b0, CMD_REF,  ERR_NOT_IDLE, "R5 R3 refresh with banks open");  // c8
    cmd(3'b010, 2'd3, 1'b1, CMD_PREA, ERR_TRAS,     "R2 all-bank precharge");          // c9
    issue(1'b1, 3'b000, 2'd0, 1'b0, 1'b1, CMD_NOP, ERR_NONE, "R1 deselect masks MRS"); // c10
    cmd(3'b011, 2'd2, 1'b0, CMD_ACT,  ERR_NONE,     "R2 bank index BA1 high");         // c11
    nop(1);                                                                             // c12
    cmd(3'b011, 2'd0, 1'b0, CMD_ACT,  ERR_TRC,      "R9 act before tRC");              // c13
    cmd(3'b100, 2'd2, 1'b1, CMD_WRA,  ERR_NONE,     "R11 write auto-precharge");       // c14
    cmd(3'b100, 2'd2, 1'b0, CMD_WR,   ERR_AP_BUSY,  "R11 write while close pending");  // c15
    nop(4);                                                                             // c16-c19
    cmd(3'b101, 2'd2, 1'b0, CMD_RD,   ERR_CLOSED,   "R11 bank closed after burst");    // c20
    cmd(3'b011, 2'd2, 1'b0, CMD_ACT,  ERR_NONE,     "R11 act exactly tRP after close");// c21
    nop(2);                                                                             // c22-c23
    cmd(3'b100, 2'd2, 1'b0, CMD_WR,   ERR_NONE,     "R7 write at tRCD");               // c24
    nop(2);                                                                             // c25-c26
    cmd(3'b010, 2'd2, 1'b0, CMD_PRE,  ERR_TWR,      "R8 precharge inside write recovery"); // c27
    cmd(3'b010, 2'd1, 1'b1, CMD_PREA, ERR_NONE,     "R2 all-bank precharge legal");    // c28
    nop(2);                                                                             // c29-c30
    cmd(3'b000, 2'd0, 1'b0, CMD_MRS,  ERR_NONE,     "R5 MRS all idle");                // c31
    cmd(3'b011, 2'd1, 1'b0, CMD_ACT,  ERR_MRS_GAP,  "R6 act right after MRS");         // c32
    nop(1);                                                                             // c33
    cmd(3'b010, 2'd1, 1'b0, CMD_PRE,  ERR_TRAS,     "R8 state kept after flagged act");// c34
    nop(3);                                                                             // c35-c37
    cmd(3'b001, 2'd0, 1'b0, CMD_REF,  ERR_NONE,     "R3 auto refresh");                // c38
    issue(1'b0, 3'b001, 2'd0, 1'b0, 1'b0, CMD_SREF, ERR_NONE, "R3 self refresh entry");// c39
    issue(1'b0, 3'b111, 2'd0, 1'b0, 1'b0, CMD_NOP,  ERR_NONE, "R1 nop cke low");       // c40
    nop(1);                                                                             // c41
    cmd(3'b110, 2'd0, 1'b0, CMD_BST,  ERR_NONE,     "R1 burst stop");                  // c42
    cmd(3'b011, 2'd3, 1'b0, CMD_ACT,  ERR_NONE,     "R2 bank index 3");                // c43

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, exp completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule